// File: doc/BRIEF.md
# Word/Byte Memory Access Port

This block sits between a microcoded datapath and a single shared RAM. It owns four registers. A word address register and a 32-bit word data register serve data loads and stores. A program-counter register and an 8-bit instruction byte register serve opcode fetch. The datapath loads the address and data registers from its result bus. The current microinstruction supplies three strobes: read, write and fetch. The port turns these strobes into RAM address, data and enable signals. It later copies the returned word or byte into the data or byte register.

Every access follows the same timing. The strobe is raised during cycle n. The request goes to the RAM during cycle n+1, using the register values loaded at the end of cycle n. The returned value appears in its register from cycle n+2. During cycle n+1 the old value is still visible. Word accesses and fetches use separate sides of the RAM, so one of each can be in progress at the same time. A small behavioural byte-array RAM is included so the port can run on its own.

Top module: `wbport_top`

## Requirements
- R1: Reset (synchronous, active high) clears the four registers, cancels pending accesses and fills the whole RAM with zeros.
- R2: On each clock edge the word address, word data and program-counter registers load the result bus when their load strobe is high. Otherwise they keep their value.
- R3: A read raised in cycle n leaves the data register unchanged through cycle n+1. From cycle n+2 the register holds the RAM word at byte address {addr[29:0],2'b00}, where addr is the word address register after the edge ending cycle n. The byte at the lowest address lands in bits 31:24.
- R4: A write raised in cycle n drives the RAM in cycle n+1 and stores the data register, as loaded at the end of cycle n, into the four bytes at {addr[29:0],2'b00}. Bits 31:24 go to the lowest address.
- R5: A fetch raised in cycle n leaves the byte register unchanged through cycle n+1. From cycle n+2 the register holds the RAM byte at the program counter, as loaded at the end of cycle n.
- R6: A read and a fetch raised in the same cycle both complete with the R3/R5 timing.
- R7: When read and write are raised together, only the write is performed and the data register is not overwritten from memory.
- R8: When returning read data and a data-register load strobe meet at the same edge, the returned data wins.
- R9: While no read or write is pending, the word-side address, write data and both word enables are zero. While no fetch is pending, the byte address and fetch enable are zero.
- R10: The RAM is indexed by the low log2(RAM_BYTES) bits of the byte address, so higher bits (including word-address bits 31:30) alias.
- R11: A fetch that reaches the RAM in the same cycle as a write to the same byte returns the byte from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| c_bus | input | 32 | Datapath result bus |
| ld_mar | input | 1 | Load word address register |
| ld_mdr | input | 1 | Load word data register |
| ld_pc | input | 1 | Load program counter |
| mem_rd | input | 1 | Word read strobe |
| mem_wr | input | 1 | Word write strobe |
| mem_fetch | input | 1 | Byte fetch strobe |
| mar_q | output | 32 | Word address register |
| mdr_q | output | 32 | Word data register |
| pc_q | output | 32 | Program counter |
| mbr_q | output | 8 | Fetched instruction byte |
| ram_word_addr | output | 32 | Byte address on the word side of the RAM |
| ram_word_rd | output | 1 | Word read enable |
| ram_word_wr | output | 1 | Word write enable |
| ram_wdata | output | 32 | Word write data |
| ram_byte_addr | output | 32 | Byte address on the fetch side of the RAM |
| ram_byte_rd | output | 1 | Fetch enable |

## Verification
The bench targets the cycle between a request and its result. A port that returned data a cycle early would show the new data-register or byte-register value in cycle n+1, and the bench checks that cycle explicitly. It issues writes whose data is loaded in the same microinstruction: a port that sampled the data register one edge too early would store the stale word. It combines read+write, read+data load at the return edge, and fetch+write to the same byte. Wrong priorities would then corrupt the data register or return the post-write byte. Aliased addresses with high bits set expose a port that indexes the RAM with the wrong bits. A reference model compares the registers and the RAM bus on every clock during a random phase, which catches buses left driven while idle.

// File: rtl/wbport_pkg.sv
package wbport_pkg;

    localparam int WORD_W = 32;
    localparam int BYTE_W = 8;
    localparam int LANES  = WORD_W / BYTE_W;

    typedef struct packed {
        logic rd;
        logic wr;
        logic fetch;
    } mem_ctl_t;

    typedef enum logic [1:0] {
        W_IDLE  = 2'd0,
        W_READ  = 2'd1,
        W_WRITE = 2'd2
    } word_op_e;

    // A write strobe overrides a read strobe in the same microinstruction.
    function automatic word_op_e resolve_word_op(mem_ctl_t ctl);
        if (ctl.wr)
            return W_WRITE;
        else if (ctl.rd)
            return W_READ;
        else
            return W_IDLE;
    endfunction

    // Word address to byte address of its first byte.
    function automatic logic [WORD_W-1:0] word_to_byte(logic [WORD_W-1:0] waddr);
        return {waddr[WORD_W-3:0], 2'b00};
    endfunction

endpackage

// File: rtl/wbport_word_side.sv
module wbport_word_side
    import wbport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] c_bus,
    input  logic              ld_mar,
    input  logic              ld_mdr,
    input  word_op_e          op_req,
    input  logic [WORD_W-1:0] ram_rdata,
    output logic [WORD_W-1:0] mar_q,
    output logic [WORD_W-1:0] mdr_q,
    output logic [WORD_W-1:0] bus_addr,
    output logic [WORD_W-1:0] bus_wdata,
    output logic              bus_rd,
    output logic              bus_wr
);

    word_op_e pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mar_q  <= '0;
            mdr_q  <= '0;
            pend_q <= W_IDLE;
        end else begin
            if (ld_mar)
                mar_q <= c_bus;
            // returning memory data beats a bus load at the same edge
            if (pend_q == W_READ)
                mdr_q <= ram_rdata;
            else if (ld_mdr)
                mdr_q <= c_bus;
            pend_q <= op_req;
        end
    end

    always_comb begin
        bus_rd    = (pend_q == W_READ);
        bus_wr    = (pend_q == W_WRITE);
        bus_addr  = (bus_rd || bus_wr) ? word_to_byte(mar_q) : '0;
        bus_wdata = bus_wr ? mdr_q : '0;
    end

endmodule

// File: rtl/wbport_byte_side.sv
module wbport_byte_side
    import wbport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] c_bus,
    input  logic              ld_pc,
    input  logic              fetch_req,
    input  logic [BYTE_W-1:0] ram_rbyte,
    output logic [WORD_W-1:0] pc_q,
    output logic [BYTE_W-1:0] mbr_q,
    output logic [WORD_W-1:0] bus_addr,
    output logic              bus_rd
);

    logic pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= '0;
            mbr_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            if (ld_pc)
                pc_q <= c_bus;
            if (pend_q)
                mbr_q <= ram_rbyte;
            pend_q <= fetch_req;
        end
    end

    always_comb begin
        bus_rd   = pend_q;
        bus_addr = pend_q ? pc_q : '0;
    end

endmodule

// File: rtl/wbport_ram.sv
module wbport_ram
    import wbport_pkg::*;
#(
    parameter int RAM_BYTES = 1024
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [$clog2(RAM_BYTES)-1:0] word_idx,
    input  logic                         word_wr,
    input  logic [WORD_W-1:0]            word_wdata,
    output logic [WORD_W-1:0]            word_rdata,
    input  logic [$clog2(RAM_BYTES)-1:0] byte_idx,
    output logic [BYTE_W-1:0]            byte_rdata
);

    localparam int IDX_W = $clog2(RAM_BYTES);

    logic [BYTE_W-1:0] mem [RAM_BYTES];
    logic [IDX_W-1:0]  base;

    assign base = {word_idx[IDX_W-1:2], 2'b00};

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < RAM_BYTES; i++)
                mem[i] <= '0;
        end else if (word_wr) begin
            for (int k = 0; k < LANES; k++)
                mem[base + IDX_W'(k)] <= word_wdata[WORD_W-1-BYTE_W*k -: BYTE_W];
        end
    end

    // combinational reads see contents before a write at the same edge
    always_comb begin
        for (int k = 0; k < LANES; k++)
            word_rdata[WORD_W-1-BYTE_W*k -: BYTE_W] = mem[base + IDX_W'(k)];
        byte_rdata = mem[byte_idx];
    end

endmodule

// File: rtl/wbport_top.sv
module wbport_top
    import wbport_pkg::*;
#(
    parameter int RAM_BYTES = 1024
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] c_bus,
    input  logic        ld_mar,
    input  logic        ld_mdr,
    input  logic        ld_pc,
    input  logic        mem_rd,
    input  logic        mem_wr,
    input  logic        mem_fetch,
    output logic [31:0] mar_q,
    output logic [31:0] mdr_q,
    output logic [31:0] pc_q,
    output logic [7:0]  mbr_q,
    output logic [31:0] ram_word_addr,
    output logic        ram_word_rd,
    output logic        ram_word_wr,
    output logic [31:0] ram_wdata,
    output logic [31:0] ram_byte_addr,
    output logic        ram_byte_rd
);

    localparam int IDX_W = $clog2(RAM_BYTES);

    mem_ctl_t          ctl;
    word_op_e          word_op;
    logic [WORD_W-1:0] word_rdata;
    logic [BYTE_W-1:0] byte_rdata;

    always_comb begin
        ctl.rd    = mem_rd;
        ctl.wr    = mem_wr;
        ctl.fetch = mem_fetch;
        word_op   = resolve_word_op(ctl);
    end

    wbport_word_side u_word (
        .clk       (clk),
        .rst       (rst),
        .c_bus     (c_bus),
        .ld_mar    (ld_mar),
        .ld_mdr    (ld_mdr),
        .op_req    (word_op),
        .ram_rdata (word_rdata),
        .mar_q     (mar_q),
        .mdr_q     (mdr_q),
        .bus_addr  (ram_word_addr),
        .bus_wdata (ram_wdata),
        .bus_rd    (ram_word_rd),
        .bus_wr    (ram_word_wr)
    );

    wbport_byte_side u_byte (
        .clk       (clk),
        .rst       (rst),
        .c_bus     (c_bus),
        .ld_pc     (ld_pc),
        .fetch_req (ctl.fetch),
        .ram_rbyte (byte_rdata),
        .pc_q      (pc_q),
        .mbr_q     (mbr_q),
        .bus_addr  (ram_byte_addr),
        .bus_rd    (ram_byte_rd)
    );

    wbport_ram #(.RAM_BYTES(RAM_BYTES)) u_ram (
        .clk        (clk),
        .rst        (rst),
        .word_idx   (ram_word_addr[IDX_W-1:0]),
        .word_wr    (ram_word_wr),
        .word_wdata (ram_wdata),
        .word_rdata (word_rdata),
        .byte_idx   (ram_byte_addr[IDX_W-1:0]),
        .byte_rdata (byte_rdata)
    );

endmodule

// File: rtl/wbport_chk.sv
module wbport_chk (
    input logic        clk,
    input logic        rst,
    input logic        ld_mar,
    input logic        ld_mdr,
    input logic        mem_rd,
    input logic        mem_wr,
    input logic        mem_fetch,
    input logic [31:0] mar_q,
    input logic [31:0] mdr_q,
    input logic [31:0] pc_q,
    input logic [7:0]  mbr_q,
    input logic [31:0] ram_word_addr,
    input logic        ram_word_rd,
    input logic        ram_word_wr,
    input logic [31:0] ram_wdata,
    input logic [31:0] ram_byte_addr,
    input logic        ram_byte_rd
);

    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!ram_word_rd && !ram_word_wr && !ram_byte_rd && mbr_q == 8'h00));

    a_r2_mar_hold: assert property (@(posedge clk) disable iff (rst)
        !ld_mar |=> $stable(mar_q));

    a_r3_mdr_gap: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && !mem_wr && !ld_mdr && !ram_word_rd) |=> $stable(mdr_q));

    a_r4_write_issue: assert property (@(posedge clk) disable iff (rst)
        mem_wr |=> (ram_word_wr && ram_wdata == mdr_q && ram_word_addr == {mar_q[29:0], 2'b00}));

    a_r5_fetch_issue: assert property (@(posedge clk) disable iff (rst)
        mem_fetch |=> (ram_byte_rd && ram_byte_addr == pc_q));

    a_r5_mbr_hold: assert property (@(posedge clk) disable iff (rst)
        !ram_byte_rd |=> $stable(mbr_q));

    a_r7_write_wins: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && mem_wr) |=> (ram_word_wr && !ram_word_rd));

    a_r9_word_idle: assert property (@(posedge clk) disable iff (rst)
        (!ram_word_rd && !ram_word_wr) |-> (ram_word_addr == 32'h0 && ram_wdata == 32'h0));

    a_r9_byte_idle: assert property (@(posedge clk) disable iff (rst)
        !ram_byte_rd |-> (ram_byte_addr == 32'h0));

endmodule

bind wbport_top wbport_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .ld_mar        (ld_mar),
    .ld_mdr        (ld_mdr),
    .mem_rd        (mem_rd),
    .mem_wr        (mem_wr),
    .mem_fetch     (mem_fetch),
    .mar_q         (mar_q),
    .mdr_q         (mdr_q),
    .pc_q          (pc_q),
    .mbr_q         (mbr_q),
    .ram_word_addr (ram_word_addr),
    .ram_word_rd   (ram_word_rd),
    .ram_word_wr   (ram_word_wr),
    .ram_wdata     (ram_wdata),
    .ram_byte_addr (ram_byte_addr),
    .ram_byte_rd   (ram_byte_rd)
);

// File: tb/tb_wbport_top.sv
module tb_wbport_top;

    localparam int NBYTES = 1024;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] c_bus = '0;
    logic        ld_mar = 0, ld_mdr = 0, ld_pc = 0;
    logic        mem_rd = 0, mem_wr = 0, mem_fetch = 0;
    logic [31:0] mar_q, mdr_q, pc_q;
    logic [7:0]  mbr_q;
    logic [31:0] ram_word_addr, ram_wdata, ram_byte_addr;
    logic        ram_word_rd, ram_word_wr, ram_byte_rd;

    int    total = 0;
    int    bad = 0;
    bit    done = 0;
    bit    mon_on = 0;
    string tag = "reset";

    always #5 clk = ~clk;

    wbport_top #(.RAM_BYTES(NBYTES)) dut (
        .clk(clk), .rst(rst), .c_bus(c_bus),
        .ld_mar(ld_mar), .ld_mdr(ld_mdr), .ld_pc(ld_pc),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_fetch(mem_fetch),
        .mar_q(mar_q), .mdr_q(mdr_q), .pc_q(pc_q), .mbr_q(mbr_q),
        .ram_word_addr(ram_word_addr), .ram_word_rd(ram_word_rd),
        .ram_word_wr(ram_word_wr), .ram_wdata(ram_wdata),
        .ram_byte_addr(ram_byte_addr), .ram_byte_rd(ram_byte_rd)
    );

    // ---------------- reference model ----------------
    logic [7:0]  m_mem [NBYTES];
    logic [31:0] m_mar, m_mdr, m_pc;
    logic [7:0]  m_mbr;
    bit          m_prd, m_pwr, m_pf;

    function automatic int m_idx(logic [31:0] byte_addr);
        return int'(byte_addr % NBYTES);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NBYTES; i++) m_mem[i] = 8'h00;
            m_mar = 0; m_mdr = 0; m_pc = 0; m_mbr = 0;
            m_prd = 0; m_pwr = 0; m_pf = 0;
        end else begin
            logic [31:0] rword;
            logic [7:0]  rbyte;
            int          b;
            b = m_idx(m_mar << 2);
            rword = {m_mem[b], m_mem[b+1], m_mem[b+2], m_mem[b+3]};
            rbyte = m_mem[m_idx(m_pc)];
            if (m_pwr) begin
                m_mem[b]   = m_mdr[31:24];
                m_mem[b+1] = m_mdr[23:16];
                m_mem[b+2] = m_mdr[15:8];
                m_mem[b+3] = m_mdr[7:0];
            end
            if (m_prd)       m_mdr = rword;
            else if (ld_mdr) m_mdr = c_bus;
            if (m_pf)   m_mbr = rbyte;
            if (ld_mar) m_mar = c_bus;
            if (ld_pc)  m_pc = c_bus;
            m_pwr = mem_wr;
            m_prd = mem_rd && !mem_wr;
            m_pf  = mem_fetch;
        end
    end

    task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s [%s] %s got=%h exp=%h", req, tag, what, got, exp);
        end
    endtask

    always @(negedge clk) begin
        if (mon_on) begin
            chk("R2", "mar", mar_q, m_mar);
            chk("R2", "pc", pc_q, m_pc);
            chk("R3", "mdr", mdr_q, m_mdr);
            chk("R5", "mbr", {24'h0, mbr_q}, {24'h0, m_mbr});
            chk("R9", "word_rd", {31'h0, ram_word_rd}, {31'h0, m_prd});
            chk("R9", "word_wr", {31'h0, ram_word_wr}, {31'h0, m_pwr});
            chk("R9", "word_addr", ram_word_addr, (m_prd || m_pwr) ? (m_mar << 2) : 32'h0);
            chk("R9", "wdata", ram_wdata, m_pwr ? m_mdr : 32'h0);
            chk("R9", "byte_rd", {31'h0, ram_byte_rd}, {31'h0, m_pf});
            chk("R9", "byte_addr", ram_byte_addr, m_pf ? m_pc : 32'h0);
        end
    end

    // drive one microinstruction at a falling edge, return at the next falling edge
    task automatic drv(logic [31:0] cb, bit lm, bit ldd, bit lp, bit r, bit w, bit f);
        c_bus = cb; ld_mar = lm; ld_mdr = ldd; ld_pc = lp;
        mem_rd = r; mem_wr = w; mem_fetch = f;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        drv(32'h0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish got=running exp=done");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        mon_on = 1;

        // R1: registers clear, RAM zero
        tag = "R1";
        chk("R1", "mar", mar_q, 32'h0);
        chk("R1", "mdr", mdr_q, 32'h0);
        chk("R1", "pc", pc_q, 32'h0);
        chk("R1", "mbr", {24'h0, mbr_q}, 32'h0);
        drv(32'h77, 0, 1, 0, 0, 0, 0);
        drv(32'h5, 1, 0, 0, 1, 0, 0);
        idle();
        chk("R1", "ram word after reset", mdr_q, 32'h0);

        // R2: loads from result bus
        tag = "R2";
        drv(32'h10, 1, 0, 1, 0, 0, 0);
        chk("R2", "mar load", mar_q, 32'h10);
        chk("R2", "pc load", pc_q, 32'h10);

        // R4: write uses data loaded in the issuing cycle
        tag = "R4";
        drv(32'h1122_3344, 0, 1, 0, 0, 1, 0);
        chk("R4", "wr enable", {31'h0, ram_word_wr}, 32'h1);
        chk("R4", "wr addr", ram_word_addr, 32'h40);
        chk("R4", "wr data", ram_wdata, 32'h1122_3344);
        drv(32'h0, 0, 1, 0, 0, 0, 0);

        // R3: read latency and byte order
        tag = "R3";
        drv(32'h0, 0, 0, 0, 1, 0, 0);
        chk("R3", "mdr in gap cycle", mdr_q, 32'h0);
        idle();
        chk("R3", "mdr after read", mdr_q, 32'h1122_3344);

        // R5: fetch latency, big-endian lane
        tag = "R5";
        drv(32'h41, 0, 0, 1, 0, 0, 1);
        chk("R5", "mbr in gap cycle", {24'h0, mbr_q}, 32'h0);
        idle();
        chk("R5", "mbr after fetch", {24'h0, mbr_q}, 32'h22);

        // R6: read and fetch together
        tag = "R6";
        drv(32'h43, 0, 1, 1, 0, 0, 0);
        drv(32'h10, 1, 0, 0, 1, 0, 1);
        idle();
        chk("R6", "mdr", mdr_q, 32'h1122_3344);
        chk("R6", "mbr", {24'h0, mbr_q}, 32'h44);

        // R7: read+write -> write only
        tag = "R7";
        drv(32'h20, 1, 0, 0, 0, 0, 0);
        drv(32'hDEAD_BEEF, 0, 1, 0, 1, 1, 0);
        chk("R7", "word_rd", {31'h0, ram_word_rd}, 32'h0);
        chk("R7", "word_wr", {31'h0, ram_word_wr}, 32'h1);
        idle();
        chk("R7", "mdr kept", mdr_q, 32'hDEAD_BEEF);
        drv(32'h0, 0, 1, 0, 0, 0, 0);
        drv(32'h0, 0, 0, 0, 1, 0, 0);
        idle();
        chk("R7", "stored word", mdr_q, 32'hDEAD_BEEF);

        // R8: returned data beats bus load
        tag = "R8";
        drv(32'h10, 1, 0, 0, 1, 0, 0);
        drv(32'h5555, 0, 1, 0, 0, 0, 0);
        chk("R8", "mdr", mdr_q, 32'h1122_3344);

        // R10: address aliasing
        tag = "R10";
        drv(32'h110, 1, 0, 0, 0, 0, 0);
        drv(32'hA5A5_0F0F, 0, 1, 0, 0, 1, 0);
        drv(32'h0, 0, 1, 0, 0, 0, 0);
        drv(32'h8000_0010, 1, 0, 0, 1, 0, 0);
        idle();
        chk("R10", "aliased word", mdr_q, 32'hA5A5_0F0F);

        // R11: fetch meets write to same byte
        tag = "R11";
        drv(32'h30, 1, 0, 0, 0, 0, 0);
        drv(32'hC0, 0, 0, 1, 0, 0, 0);
        drv(32'hCAFE_F00D, 0, 1, 0, 0, 1, 1);
        idle();
        chk("R11", "pre-write byte", {24'h0, mbr_q}, 32'h00);
        drv(32'h0, 0, 0, 0, 0, 0, 1);
        idle();
        chk("R11", "post-write byte", {24'h0, mbr_q}, 32'hCA);

        // random mix against the model
        tag = "random";
        for (int i = 0; i < 600; i++) begin
            logic [31:0] cb;
            cb = ($urandom_range(0, 3) == 0) ? $urandom : 32'($urandom_range(0, 80));
            drv(cb, ($urandom_range(0, 2) == 0), ($urandom_range(0, 2) == 0),
                ($urandom_range(0, 2) == 0), ($urandom_range(0, 2) == 0),
                ($urandom_range(0, 3) == 0), ($urandom_range(0, 2) == 0));
        end
        idle();
        idle();

        done = 1;
        summary();
        $finish;
    end

endmodule